// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Compare

This block is a purely combinational integer arithmetic and logic unit. Two 32-bit operands and a 4-bit operation code go in. A 32-bit result comes out, together with a carry flag, a zero flag and a signed overflow flag. The operations are the bitwise logic functions AND, OR, XOR and NOR, plus addition, subtraction and signed or unsigned set-on-less-than.

The datapath is a ripple chain of identical one-bit slices. Each slice can invert either of its operand bits. It picks its output from the AND, OR or XOR of the (possibly inverted) bits, the adder sum, or a less-than input. Only bit 0 has a live less-than input. It is driven by the compare outcome that the top of the chain works out, and every other slice sees 0 there. Subtraction and comparison share one path: B is inverted and the carry into bit 0 is forced to 1. A small decoder turns the operation code into a struct of slice strobes.

Top module: `alu_core`

## Requirements
- R1: Operation codes 4'b0000, 4'b0001, 4'b1101 and 4'b1100 give the bitwise AND, OR, XOR and NOR of the two operands, respectively.
- R2: Code 4'b0010 gives the 32-bit sum of the operands. The carry flag is the carry out of bit 31 of that sum.
- R3: For add and subtract, the overflow flag is 1 exactly when the true signed result does not fit in 32 bits. An add whose operands differ in sign never flags overflow, and neither does a subtract whose operands share a sign.
- R4: Code 4'b0110 gives operand A minus operand B, modulo 2^32. The carry flag is 1 exactly when A is greater than or equal to B as unsigned numbers.
- R5: Code 4'b0111 gives 1 when A is less than B as signed two's complement numbers and 0 otherwise, with bits 31..1 at 0. The answer stays correct when A minus B overflows.
- R6: Code 4'b1000 gives 1 when A is less than B as unsigned numbers and 0 otherwise, with bits 31..1 at 0.
- R7: The zero flag is 1 exactly when all 32 result bits are 0.
- R8: Any code not listed in R1, R2, R4, R5 or R6 gives a result of 0, carry 0 and overflow 0.
- R9: The four logic operations give carry 0 and overflow 0. Both compare operations report the carry and overflow of A minus B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aIn | input | 32 | Operand A |
| bIn | input | 32 | Operand B |
| opSel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Carry out of the most significant slice (arithmetic and compare only) |
| zeroFlag | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Signed overflow (arithmetic and compare only) |

## Verification
The hardest case to reach is a signed compare where A minus B overflows. Here the raw sign bit of the difference gives the wrong answer, and only the overflow correction makes the result right. Uniform random operands hit this only now and then. The stimulus therefore pairs the extreme values (most negative, most positive, -1, 0, 1) in every combination, for both compare codes and for subtract. It also adds random operands forced to opposite signs, so that overflow and non-overflow differences both occur many times.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SLTU = 4'b1000,
    OP_NOR  = 4'b1100,
    OP_XOR  = 4'b1101
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_AND  = 3'd0,
    SEL_OR   = 3'd1,
    SEL_XOR  = 3'd2,
    SEL_SUM  = 3'd3,
    SEL_LESS = 3'd4,
    SEL_ZERO = 3'd5
  } sliceSel_e;

  typedef struct packed {
    logic      aInvert;
    logic      bInvert;
    logic      carryIn;
    sliceSel_e sel;
    logic      arith;
    logic      lessUnsigned;
  } aluStrobes_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic        aBit,
  input  logic        bBit,
  input  logic        carryIn,
  input  logic        lessIn,
  input  aluStrobes_t ctrl,
  output logic        resBit,
  output logic        carryOut,
  output logic        sumBit
);

  logic aEff;
  logic bEff;

  always_comb begin
    aEff     = aBit ^ ctrl.aInvert;
    bEff     = bBit ^ ctrl.bInvert;
    sumBit   = aEff ^ bEff ^ carryIn;
    carryOut = (aEff & bEff) | (carryIn & (aEff ^ bEff));
    unique case (ctrl.sel)
      SEL_AND:  resBit = aEff & bEff;
      SEL_OR:   resBit = aEff | bEff;
      SEL_XOR:  resBit = aEff ^ bEff;
      SEL_SUM:  resBit = sumBit;
      SEL_LESS: resBit = lessIn;
      default:  resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '{aInvert: 1'b0, bInvert: 1'b0, carryIn: 1'b0,
                sel: SEL_ZERO, arith: 1'b0, lessUnsigned: 1'b0};
    case (opSel)
      OP_AND: strobes.sel = SEL_AND;
      OP_OR:  strobes.sel = SEL_OR;
      OP_XOR: strobes.sel = SEL_XOR;
      OP_NOR: begin
        strobes.aInvert = 1'b1;
        strobes.bInvert = 1'b1;
        strobes.sel     = SEL_AND;
      end
      OP_ADD: begin
        strobes.sel   = SEL_SUM;
        strobes.arith = 1'b1;
      end
      OP_SUB: begin
        strobes.bInvert = 1'b1;
        strobes.carryIn = 1'b1;
        strobes.sel     = SEL_SUM;
        strobes.arith   = 1'b1;
      end
      OP_SLT, OP_SLTU: begin
        strobes.bInvert      = 1'b1;
        strobes.carryIn      = 1'b1;
        strobes.sel          = SEL_LESS;
        strobes.arith        = 1'b1;
        strobes.lessUnsigned = (opSel == OP_SLTU);
      end
      default: strobes.sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumBits;
  logic             rawOvf;
  logic             setSigned;
  logic             lessBit0;

  assign carryChain[0] = strobes.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lessHere;
    if (i == 0) begin : g_lsb
      assign lessHere = lessBit0;
    end else begin : g_upper
      assign lessHere = 1'b0;
    end
    alu_slice u_slice (
      .aBit    (aIn[i]),
      .bBit    (bIn[i]),
      .carryIn (carryChain[i]),
      .lessIn  (lessHere),
      .ctrl    (strobes),
      .resBit  (result[i]),
      .carryOut(carryChain[i+1]),
      .sumBit  (sumBits[i])
    );
  end

  // overflow: carry into the top slice differs from carry out of it
  assign rawOvf    = carryChain[MSB] ^ carryChain[WIDTH];
  // set output of the top slice, corrected for overflow
  assign setSigned = sumBits[MSB] ^ rawOvf;
  assign lessBit0  = strobes.lessUnsigned ? ~carryChain[WIDTH] : setSigned;

  assign carryOut = strobes.arith & carryChain[WIDTH];
  assign ovfFlag  = strobes.arith & rawOvf;
  assign zeroFlag = ~|result;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [31:0] aIn,
  input  logic [31:0] bIn,
  input  logic [3:0]  opSel,
  output logic [31:0] result,
  output logic        carryOut,
  output logic        zeroFlag,
  output logic        ovfFlag
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu_datapath #(.WIDTH(32)) u_dp (
    .aIn     (aIn),
    .bIn     (bIn),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .zeroFlag(zeroFlag),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker (
  input logic [31:0] aIn,
  input logic [31:0] bIn,
  input logic [3:0]  opSel,
  input logic [31:0] result,
  input logic        carryOut,
  input logic        zeroFlag,
  input logic        ovfFlag
);

  logic isLogic;
  logic isCmp;
  logic isValid;

  always_comb begin
    isLogic = (opSel == 4'b0000) || (opSel == 4'b0001) ||
              (opSel == 4'b1100) || (opSel == 4'b1101);
    isCmp   = (opSel == 4'b0111) || (opSel == 4'b1000);
    isValid = isLogic || isCmp || (opSel == 4'b0010) || (opSel == 4'b0110);

    // R7
    p_zero_match_r7: assert (zeroFlag == (result == 32'd0));
    // R9
    p_logic_flags_r9: assert (!isLogic || (!carryOut && !ovfFlag));
    // R5 / R6
    p_cmp_binary_r5: assert (!isCmp || (result[31:1] == 31'd0));
    // R3
    p_no_overflow_r3: assert (!(opSel == 4'b0010 && aIn[31] != bIn[31]) || !ovfFlag);
    // R4
    p_sub_carry_r4: assert (!(opSel == 4'b0110) || (carryOut == (aIn >= bIn)));
    // R8
    p_bad_code_r8: assert (isValid || (result == 32'd0 && !carryOut && !ovfFlag));
  end

endmodule

bind alu_core alu_core_checker i_chk (
  .aIn     (aIn),
  .bIn     (bIn),
  .opSel   (opSel),
  .result  (result),
  .carryOut(carryOut),
  .zeroFlag(zeroFlag),
  .ovfFlag (ovfFlag)
);

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] aIn = '0;
  logic [31:0] bIn = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        carryOut;
  logic        zeroFlag;
  logic        ovfFlag;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu_core i_alu_core (
    .aIn(aIn), .bIn(bIn), .opSel(opSel),
    .result(result), .carryOut(carryOut), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  // queue of pending expectations: {op, a, b}
  logic [67:0] pending[$];

  function automatic string resTag(logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R1";
      4'b0010: return "R2";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1000: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s op actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic evaluate(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    logic [32:0] wide;
    logic [31:0] eRes;
    logic        eC;
    logic        eV;
    string       flagTag;
    eRes = '0; eC = 1'b0; eV = 1'b0;
    flagTag = "R8";
    case (op)
      4'b0000: begin eRes = a & b;    flagTag = "R9"; end
      4'b0001: begin eRes = a | b;    flagTag = "R9"; end
      4'b1101: begin eRes = a ^ b;    flagTag = "R9"; end
      4'b1100: begin eRes = ~(a | b); flagTag = "R9"; end
      4'b0010: begin
        wide = {1'b0, a} + {1'b0, b};
        eRes = wide[31:0]; eC = wide[32];
        eV = (a[31] == b[31]) && (eRes[31] != a[31]);
        flagTag = "R3";
      end
      4'b0110, 4'b0111, 4'b1000: begin
        wide = {1'b0, a} - {1'b0, b};
        eRes = wide[31:0];
        eC = (a >= b);
        eV = (a[31] != b[31]) && (eRes[31] != a[31]);
        flagTag = (op == 4'b0110) ? "R3" : "R9";
        if (op == 4'b0111) eRes = {31'd0, ($signed(a) < $signed(b))};
        if (op == 4'b1000) eRes = {31'd0, (a < b)};
      end
      default: ;
    endcase
    check(resTag(op), "result", result, eRes);
    check(flagTag, "carry", {31'd0, carryOut}, {31'd0, eC});
    check(flagTag, "overflow", {31'd0, ovfFlag}, {31'd0, eV});
    check("R7", "zero", {31'd0, zeroFlag}, {31'd0, (eRes == 32'd0)});
  endtask

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opSel = op; aIn = a; bIn = b;
    pending.push_back({op, a, b});
  endtask

  // compare on every rising edge, inputs settled since the falling edge
  always @(posedge clk) begin
    if (rstN && pending.size() > 0) begin
      logic [67:0] item;
      item = pending.pop_front();
      #1 evaluate(item[67:64], item[63:32], item[31:0]);
    end
  end

  initial begin
    logic [31:0] corners[5];
    logic [3:0]  validOps[8];
    corners  = '{32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff, 32'h0, 32'h1};
    validOps = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1000, 4'b1100, 4'b1101};
    repeat (3) @(negedge clk);
    // reset-state check: all-zero inputs give AND of zeros (R7, R1)
    #1;
    check("R7", "reset zero", {31'd0, zeroFlag}, 32'd1);
    check("R1", "reset result", result, 32'd0);
    rstN = 1'b1;
    // corner pairs for every code, incl. overflowing compares (R5, R3)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(op[3:0], corners[i], corners[j]);
    // equal operands: subtract gives zero, carry 1 (R4, R7)
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);
    // add that wraps to zero with carry (R2, R7)
    apply(4'b0010, 32'hffff_ffff, 32'h1);
    // random over valid codes
    for (int k = 0; k < 3000; k++)
      apply(validOps[$urandom_range(7)], $urandom, $urandom);
    // random opposite-sign operands for compare and subtract (R5, R3)
    for (int k = 0; k < 1000; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom | 32'h8000_0000;
      b = $urandom & 32'h7fff_ffff;
      if (k[0]) apply(4'b0111, a, b); else apply(4'b0111, b, a);
      apply(4'b0110, a, b);
    end
    // undefined codes with random data (R8)
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      op = 4'($urandom);
      if (op inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1000, 4'b1100, 4'b1101})
        op = 4'b1111;
      apply(op, $urandom, $urandom);
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule